// File: doc/BRIEF.md
# Programmable-Phase Multiplexed Bus Master

This block drives an external parallel bus whose address and data share one set of lines. An internal client offers one access at a time on a ready/valid request port: an address, write data, a read/write flag and the index of the chip select to use. The block runs the access as five phases in a fixed order. First an address phase with the latch enable high, then a single fixed address-hold cycle. After that come data setup, strobe, hold and recovery. When the hold phase ends, a one-cycle done pulse returns any read data to the client.

The length of each phase comes from a 14-bit timing word that is sampled when the request is accepted. Each field stores its length minus one. Bits [1:0] set the address phase (1 to 4 cycles). Bits [3:2] set the setup phase (1 to 4). Bits [7:4] set the strobe phase (1 to 16). Bits [9:8] set the hold phase (1 to 4). Bits [13:10] set the recovery phase (1 to 16). The shared lines come out as separate out, output-enable and in signals, so the pad ring can build the tristate buffer.

Top module: `mpx_bus_master`

## Requirements
- R1: After a request is accepted, `bus_ale` is high for exactly cfg[1:0]+1 cycles. During those cycles `bus_ad_oe` is 1, `bus_ad_out` carries the address and every chip select stays high.
- R2: In the single cycle after `bus_ale` falls, `bus_ale` is 0, `bus_ad_oe` is 1 and `bus_ad_out` still carries the address.
- R3: The setup phase lasts cfg[3:2]+1 cycles with both strobes high. During a write, `bus_ad_out` carries the write data throughout this phase.
- R4: The strobe phase lasts cfg[7:4]+1 cycles. `bus_rd_n` is low for a read and `bus_wr_n` is low for a write, and the two strobes are never low together.
- R5: The hold phase lasts cfg[9:8]+1 cycles after the strobe rises. Both strobes are high, the chip select stays low, and a write keeps its data on `bus_ad_out`.
- R6: The recovery phase lasts cfg[13:10]+1 cycles. Throughout it every chip select and strobe is high, `bus_ale` is 0 and `bus_ad_oe` is 0, and `req_ready` is low.
- R7: Bit `req_cs` of the active-low `bus_cs_n` is low from the address-hold cycle through the last hold cycle. No other bit is low, and all bits are high at any other time.
- R8: For a read, `bus_ad_oe` is 0 from the setup phase through the hold phase. For a write, it is 1 over the same span.
- R9: For a read, `rd_data` takes the value on `bus_ad_in` in the last strobe cycle. `done` is high for exactly the one cycle after the hold phase, and `rd_data` is valid in that cycle.
- R10: `req_ready` is high only when no access is in progress. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. The timing word is sampled at that edge, so later changes do not affect the running access.
- R11: While reset is applied and after it is released, `bus_ale` is 0, all chip selects and both strobes are 1, `bus_ad_oe` is 0, `done` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AD_W | Address for the access |
| req_wdata | input | AD_W | Write data |
| req_cs | input | CSI_W | Index of the chip select to assert |
| cfg_timing | input | 14 | Phase lengths, each field stores length minus one |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | AD_W | Captured read data |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_cs_n | output | CS_N | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_out | output | AD_W | Shared lines, output value |
| bus_ad_oe | output | 1 | Shared lines, output enable |
| bus_ad_in | input | AD_W | Shared lines, input value |

## Verification
The bound checker checks the pin relations on every cycle. The two strobes are never low together. No chip select is low while the latch enable is high, and at most one is low at any time. The shared lines are released during a read strobe and driven during a write strobe, and the address stays put in the cycle after the latch enable falls. It also checks that done lasts one cycle and that the bus is quiet whenever the block reports ready. The exact phase lengths for each field value, the sampling of read data in the last strobe cycle, and the sampling of the timing word at acceptance only show up in the bench's scenarios. Those scenarios use minimum, maximum and mixed timing words, a bus model whose read data changes on every strobe cycle, and a timing word that is altered mid-access.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

   localparam int SHORT_W = 2;
   localparam int LONG_W  = 4;
   localparam int CNT_W   = LONG_W;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_AHOLD,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_RECOV
   } mpx_phase_e;

   typedef struct packed {
      logic [LONG_W-1:0]  recov;
      logic [SHORT_W-1:0] hold;
      logic [LONG_W-1:0]  strobe;
      logic [SHORT_W-1:0] setup;
      logic [SHORT_W-1:0] addr;
   } mpx_timing_t;

   localparam int CFG_W = $bits(mpx_timing_t);

   function automatic mpx_phase_e next_phase(input mpx_phase_e ph);
      case (ph)
         PH_ADDR:   return PH_AHOLD;
         PH_AHOLD:  return PH_SETUP;
         PH_SETUP:  return PH_STROBE;
         PH_STROBE: return PH_HOLD;
         PH_HOLD:   return PH_RECOV;
         default:   return PH_IDLE;
      endcase
   endfunction

   function automatic logic [CNT_W-1:0] phase_load(input mpx_phase_e ph,
                                                   input mpx_timing_t tm);
      case (ph)
         PH_ADDR:   return CNT_W'(tm.addr);
         PH_SETUP:  return CNT_W'(tm.setup);
         PH_STROBE: return tm.strobe;
         PH_HOLD:   return CNT_W'(tm.hold);
         PH_RECOV:  return tm.recov;
         default:   return '0;
      endcase
   endfunction

endpackage

// File: rtl/mpx_phase_seq.sv
module mpx_phase_seq
   import mpx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  mpx_timing_t cfg_in,
   output mpx_phase_e  phase,
   output logic        phase_last
);

   mpx_timing_t      tm_q;
   logic [CNT_W-1:0] cnt_q;
   mpx_phase_e       ph_nxt;

   assign phase_last = (cnt_q == '0);
   assign ph_nxt     = next_phase(phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
         tm_q  <= '0;
      end else if (phase == PH_IDLE) begin
         if (start) begin
            tm_q  <= cfg_in;
            phase <= PH_ADDR;
            cnt_q <= phase_load(PH_ADDR, cfg_in);
         end
      end else if (phase_last) begin
         phase <= ph_nxt;
         cnt_q <= phase_load(ph_nxt, tm_q);
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/mpx_pin_drive.sv
module mpx_pin_drive
   import mpx_pkg::*;
#(
   parameter int AD_W  = 16,
   parameter int CS_N  = 4,
   parameter int CSI_W = 2
)(
   input  mpx_phase_e       phase,
   input  logic             lat_write,
   input  logic [AD_W-1:0]  lat_addr,
   input  logic [AD_W-1:0]  lat_wdata,
   input  logic [CSI_W-1:0] lat_cs,
   output logic             bus_ale,
   output logic [CS_N-1:0]  bus_cs_n,
   output logic             bus_rd_n,
   output logic             bus_wr_n,
   output logic [AD_W-1:0]  bus_ad_out,
   output logic             bus_ad_oe
);

   logic addr_on;
   logic data_on;
   logic cs_on;
   logic strobe_on;

   assign addr_on   = (phase == PH_ADDR) || (phase == PH_AHOLD);
   assign data_on   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign cs_on     = (phase == PH_AHOLD) || data_on;
   assign strobe_on = (phase == PH_STROBE);

   assign bus_ale   = (phase == PH_ADDR);
   assign bus_rd_n  = !(strobe_on && !lat_write);
   assign bus_wr_n  = !(strobe_on && lat_write);
   assign bus_ad_oe = addr_on || (data_on && lat_write);

   always_comb begin
      if (addr_on)                    bus_ad_out = lat_addr;
      else if (data_on && lat_write)  bus_ad_out = lat_wdata;
      else                            bus_ad_out = '0;
   end

   for (genvar i = 0; i < CS_N; i++) begin : g_cs
      assign bus_cs_n[i] = !(cs_on && (lat_cs == CSI_W'(i)));
   end

endmodule

// File: rtl/mpx_bus_master.sv
module mpx_bus_master
   import mpx_pkg::*;
#(
   parameter int AD_W  = 16,
   parameter int CS_N  = 4,
   localparam int CSI_W = (CS_N > 1) ? $clog2(CS_N) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [AD_W-1:0]  req_addr,
   input  logic [AD_W-1:0]  req_wdata,
   input  logic [CSI_W-1:0] req_cs,
   input  logic [CFG_W-1:0] cfg_timing,
   output logic             done,
   output logic [AD_W-1:0]  rd_data,
   output logic             bus_ale,
   output logic [CS_N-1:0]  bus_cs_n,
   output logic             bus_rd_n,
   output logic             bus_wr_n,
   output logic [AD_W-1:0]  bus_ad_out,
   output logic             bus_ad_oe,
   input  logic [AD_W-1:0]  bus_ad_in
);

   if (AD_W < 1) begin : g_bad_width
      $error("mpx_bus_master: AD_W must be at least 1");
   end
   if (CS_N < 1) begin : g_bad_cs
      $error("mpx_bus_master: CS_N must be at least 1");
   end

   mpx_phase_e       phase;
   logic             phase_last;
   logic             accept;
   logic             lat_write;
   logic [AD_W-1:0]  lat_addr;
   logic [AD_W-1:0]  lat_wdata;
   logic [CSI_W-1:0] lat_cs;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   mpx_phase_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .cfg_in     (mpx_timing_t'(cfg_timing)),
      .phase      (phase),
      .phase_last (phase_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_write <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_cs    <= '0;
      end else if (accept) begin
         lat_write <= req_write;
         lat_addr  <= req_addr;
         lat_wdata <= req_wdata;
         lat_cs    <= req_cs;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         done    <= 1'b0;
      end else begin
         done <= (phase == PH_HOLD) && phase_last;
         if ((phase == PH_STROBE) && phase_last && !lat_write)
            rd_data <= bus_ad_in;
      end
   end

   mpx_pin_drive #(
      .AD_W  (AD_W),
      .CS_N  (CS_N),
      .CSI_W (CSI_W)
   ) u_pins (
      .phase      (phase),
      .lat_write  (lat_write),
      .lat_addr   (lat_addr),
      .lat_wdata  (lat_wdata),
      .lat_cs     (lat_cs),
      .bus_ale    (bus_ale),
      .bus_cs_n   (bus_cs_n),
      .bus_rd_n   (bus_rd_n),
      .bus_wr_n   (bus_wr_n),
      .bus_ad_out (bus_ad_out),
      .bus_ad_oe  (bus_ad_oe)
   );

endmodule

// File: rtl/mpx_bus_master_chk.sv
module mpx_bus_master_chk
   import mpx_pkg::*;
#(
   parameter int AD_W = 16,
   parameter int CS_N = 4
)(
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            done,
   input logic            bus_ale,
   input logic [CS_N-1:0] bus_cs_n,
   input logic            bus_rd_n,
   input logic            bus_wr_n,
   input logic [AD_W-1:0] bus_ad_out,
   input logic            bus_ad_oe
);

   localparam int MAX_STROBE = 1 << LONG_W;

   logic [LONG_W:0] strobe_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  strobe_run <= '0;
      else if (!bus_rd_n || !bus_wr_n) strobe_run <= strobe_run + 1'b1;
      else                         strobe_run <= '0;
   end

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ale) |-> bus_ad_oe && $stable(bus_ad_out)); // R2

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_n || bus_wr_n); // R4

   AST_STROBE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_run <= (LONG_W+1)'(MAX_STROBE)); // R4

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n)); // R7

   AST_CS_OFF_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> &bus_cs_n); // R7

   AST_STROBE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_n) |-> !(&bus_cs_n)); // R7

   AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_ad_oe); // R8

   AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> bus_ad_oe); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&bus_cs_n) && bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe); // R10

endmodule

bind mpx_bus_master mpx_bus_master_chk #(.AD_W(AD_W), .CS_N(CS_N)) u_chk (.*);

// File: tb/mpx_bus_master_bench.sv
module mpx_bus_master_bench;

   localparam int AD_W  = 16;
   localparam int CS_N  = 4;
   localparam int CSI_W = 2;
   localparam int N_ACC = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic             req_write = 1'b0;
   logic [AD_W-1:0]  req_addr = '0;
   logic [AD_W-1:0]  req_wdata = '0;
   logic [CSI_W-1:0] req_cs = '0;
   logic [13:0]      cfg_timing = '0;
   logic             done;
   logic [AD_W-1:0]  rd_data;
   logic             bus_ale;
   logic [CS_N-1:0]  bus_cs_n;
   logic             bus_rd_n;
   logic             bus_wr_n;
   logic [AD_W-1:0]  bus_ad_out;
   logic             bus_ad_oe;
   logic [AD_W-1:0]  bus_ad_in;

   logic [AD_W-1:0]  dev_base = '0;
   logic [AD_W-1:0]  strobe_cyc = '0;

   int total = 0;
   int bad = 0;
   int mon_count = 0;
   bit finished = 1'b0;

   typedef struct {
      logic            w;
      logic [AD_W-1:0] addr;
      logic [AD_W-1:0] wdata;
      logic [AD_W-1:0] rexp;
      int              cs;
      int              t1, t2, t3, t4, t5;
   } item_t;

   item_t exp_q[$];

   always #10 clk = ~clk;

   mpx_bus_master #(.AD_W(AD_W), .CS_N(CS_N)) u_mpx_bus_master (.*);

   // bus device model: read data changes on every strobe cycle
   always @(posedge clk) begin
      if (bus_rd_n) strobe_cyc <= '0;
      else          strobe_cyc <= strobe_cyc + 1'b1;
   end
   assign bus_ad_in = dev_base ^ strobe_cyc;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic w, input logic [AD_W-1:0] addr,
                       input logic [AD_W-1:0] wdata, input int cs,
                       input int t1, input int t2, input int t3,
                       input int t4, input int t5, input logic [AD_W-1:0] base);
      item_t it;
      it.w = w; it.addr = addr; it.wdata = wdata; it.cs = cs;
      it.t1 = t1; it.t2 = t2; it.t3 = t3; it.t4 = t4; it.t5 = t5;
      it.rexp = base ^ AD_W'(t3 - 1);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      exp_q.push_back(it);
      dev_base   = base;
      req_valid  = 1'b1;
      req_write  = w;
      req_addr   = addr;
      req_wdata  = wdata;
      req_cs     = CSI_W'(cs);
      cfg_timing[1:0]   = 2'(t1 - 1);
      cfg_timing[3:2]   = 2'(t2 - 1);
      cfg_timing[7:4]   = 4'(t3 - 1);
      cfg_timing[9:8]   = 2'(t4 - 1);
      cfg_timing[13:10] = 4'(t5 - 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R10", "ready low after accept", 32'(req_ready), 32'd0);
      // later timing changes must not touch the running access (R10)
      cfg_timing = ~cfg_timing;
      req_addr   = ~addr;
   endtask

   task automatic watch(input item_t it);
      int n;
      logic [CS_N-1:0] csx;
      csx = ~(CS_N'(1) << it.cs);
      n = 0;
      while (bus_ale === 1'b1 && n < 40) begin
         chk(bus_ad_oe && bus_ad_out == it.addr && (&bus_cs_n), "R1", "address phase drive",
             {15'd0, bus_ad_oe, bus_ad_out}, {15'd0, 1'b1, it.addr});
         n++;
         @(negedge clk);
      end
      chk(n == it.t1, "R1", "ALE length", n, it.t1);
      chk(!bus_ale && bus_ad_oe && bus_ad_out == it.addr, "R2", "address hold cycle",
          {15'd0, bus_ad_oe, bus_ad_out}, {15'd0, 1'b1, it.addr});
      chk(bus_cs_n == csx, "R7", "cs in address hold", 32'(bus_cs_n), 32'(csx));
      @(negedge clk);
      n = 0;
      while (bus_rd_n && bus_wr_n && n < 40) begin
         chk(bus_ad_oe == it.w, "R8", "oe in setup", 32'(bus_ad_oe), 32'(it.w));
         if (it.w) chk(bus_ad_out == it.wdata, "R3", "setup write data", 32'(bus_ad_out), 32'(it.wdata));
         chk(bus_cs_n == csx, "R7", "cs in setup", 32'(bus_cs_n), 32'(csx));
         n++;
         @(negedge clk);
      end
      chk(n == it.t2, "R3", "setup length", n, it.t2);
      n = 0;
      while ((it.w ? !bus_wr_n : !bus_rd_n) && n < 40) begin
         chk(it.w ? bus_rd_n : bus_wr_n, "R4", "other strobe high", 32'(it.w ? bus_rd_n : bus_wr_n), 32'd1);
         chk(bus_ad_oe == it.w, "R8", "oe in strobe", 32'(bus_ad_oe), 32'(it.w));
         chk(bus_cs_n == csx, "R7", "cs in strobe", 32'(bus_cs_n), 32'(csx));
         n++;
         @(negedge clk);
      end
      chk(n == it.t3, "R4", "strobe length", n, it.t3);
      n = 0;
      while (bus_cs_n == csx && n < 40) begin
         chk(bus_rd_n && bus_wr_n, "R5", "strobes high in hold", {bus_rd_n, bus_wr_n}, 32'd3);
         chk(bus_ad_oe == it.w, "R8", "oe in hold", 32'(bus_ad_oe), 32'(it.w));
         if (it.w) chk(bus_ad_out == it.wdata, "R5", "hold write data", 32'(bus_ad_out), 32'(it.wdata));
         n++;
         @(negedge clk);
      end
      chk(n == it.t4, "R5", "hold length", n, it.t4);
      chk(done, "R9", "done after hold", 32'(done), 32'd1);
      if (!it.w) chk(rd_data == it.rexp, "R9", "read data sampled at last strobe cycle",
                     32'(rd_data), 32'(it.rexp));
      n = 0;
      while (!req_ready && n < 40) begin
         chk(done == (n == 0), "R9", "done single pulse", 32'(done), 32'(n == 0));
         chk((&bus_cs_n) && bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe, "R6", "bus idle in recovery",
             {bus_cs_n, bus_rd_n, bus_wr_n, bus_ale, bus_ad_oe}, {4'hf, 4'b1100});
         n++;
         @(negedge clk);
      end
      chk(n == it.t5, "R6", "recovery length", n, it.t5);
   endtask

   // monitor: pops an expected access when ALE rises
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && bus_ale === 1'b1) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "access without request", 32'd1, 32'd0);
            end else begin
               watch(exp_q.pop_front());
            end
            mon_count++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "R10", "watchdog expired", 32'(mon_count), 32'(N_ACC));
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: state during reset
      chk(!bus_ale && (&bus_cs_n) && bus_rd_n && bus_wr_n && !bus_ad_oe && !done && req_ready,
          "R11", "state in reset", {bus_ale, bus_cs_n, bus_rd_n, bus_wr_n, bus_ad_oe, done, req_ready},
          {1'b0, 4'hf, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!bus_ale && (&bus_cs_n) && bus_rd_n && bus_wr_n && !bus_ad_oe && !done && req_ready,
          "R11", "state after reset", {bus_ale, bus_cs_n, bus_rd_n, bus_wr_n, bus_ad_oe, done, req_ready},
          {1'b0, 4'hf, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});

      send(1'b1, 16'h1234, 16'hBEEF, 0, 1, 1, 1, 1, 1, 16'h0000);
      send(1'b0, 16'h0042, 16'h0000, 0, 1, 1, 1, 1, 1, 16'hA5A0);
      send(1'b1, 16'hFFFE, 16'h5A5A, 3, 4, 4, 16, 4, 16, 16'h0000);
      send(1'b0, 16'h8001, 16'h0000, 2, 4, 4, 16, 4, 16, 16'hC3C0);
      send(1'b1, 16'h0F0F, 16'h1357, 1, 2, 3, 5, 1, 7, 16'h0000);
      send(1'b0, 16'h7E7E, 16'h0000, 1, 3, 1, 9, 2, 1, 16'h6600);
      send(1'b0, 16'h2468, 16'h0000, 0, 1, 4, 2, 3, 4, 16'h9990);
      send(1'b1, 16'hABCD, 16'hCAFE, 2, 4, 2, 1, 4, 2, 16'h0000);

      while (mon_count < N_ACC || !req_ready) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R10", "all accesses seen", exp_q.size(), 32'd0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule